// File: doc/BRIEF.md
# Rounding Fixed-Point Divider

This block divides one signed 16-bit fixed-point value by another. Both operands share a fraction count `QF` that is fixed when the block is built, and the quotient uses the same format. Before dividing, the dividend is widened to a 32-bit container and shifted left by `QF` places. Half of the divisor, truncated toward zero, is then added to or subtracted from it. It is added when the shifted dividend and the divisor have the same sign and subtracted when they do not. The final division truncates toward zero, so the correction makes the result round to the nearest value, with exact halves moving away from zero.

The division runs bit-serially, one quotient bit per clock, over 32 steps on operand magnitudes. The sign is applied at the end. A caller pulses `start` while the block is idle and then waits for the one-cycle `done` pulse. The quotient and the zero-divisor flag stay in place until the next division completes. A zero divisor skips the serial steps and returns a fixed code at once.

Top module: `qdiv_round`

## Requirements
- R1: While reset is applied and right after it, `busy`, `done`, `div_by_zero` and `quotient` are all zero.
- R2: When `start` is seen with the block idle and a nonzero divisor, `busy` rises on the next cycle and stays high for exactly 32 cycles. `done` is high for one cycle, in the cycle where `busy` has just dropped.
- R3: A `start` pulse seen while `busy` is high is ignored. The running division keeps its operands and its timing.
- R4: The quotient equals the low 16 bits of trunc((D·2^QF ± trunc(V/2)) / V), where D is the dividend and V the divisor, both signed. The plus sign applies when D·2^QF and V are both non-negative or both negative. All truncation is toward zero.
- R5: An exact half step rounds away from zero. With QF=8, D=1 and V=512 give 0x0001, and D=-1 and V=512 give 0xFFFF.
- R6: There is no saturation, so a quotient out of range wraps to its low 16 bits. With QF=8, D=0x7FFF and V=1 give 0xFF00, and D=-32768 and V=1 give 0x0000.
- R7: A `start` with a zero divisor completes on the next cycle without raising `busy`. It sets `done` and `div_by_zero` and sets `quotient` to 0x7FFF for a non-negative dividend or 0x8000 for a negative one.
- R8: `quotient` and `div_by_zero` change only in a cycle where `done` is high. A completed nonzero-divisor division clears `div_by_zero`.
- R9: Operands equal to -32768 are handled exactly. With QF=8, D=V=-32768 gives 0x0100. With QF=0, the same operands give 0x0001.
- R10: With QF=0 the shifted dividend is just the sign-extended dividend. D=7 and V=2 give 0x0004, and D=-7 and V=2 give 0xFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend | input | 16 | Signed fixed-point numerator |
| divisor | input | 16 | Signed fixed-point denominator |
| busy | output | 1 | Serial division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Rounded signed quotient, held between completions |
| div_by_zero | output | 1 | Last completed request had a zero divisor |

## Verification
The assertions assume that reset is held for some cycles before any request. They also assume that `divisor` is a defined value whenever `start` is high, since the zero-divisor property and the run-length counter both key off it. The bench holds reset for several cycles and changes operands and `start` only on falling edges. Its random phase draws divisors from a set that includes zero, ±1, ±2, -32768 and 32767. It also raises `start` at random moments, including in the middle of a division, so the ignored-start and fixed-latency properties are exercised without ever breaking these assumptions.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} qd_state_e;
endpackage

// File: rtl/qdiv_prep.sv
// Operand stage: upscale, half-divisor correction, magnitudes and result sign.
module qdiv_prep #(
  parameter int W  = 16,
  parameter int QF = 8,
  parameter int NW = 2 * W
) (
  input  logic signed [W-1:0] num_i,
  input  logic signed [W-1:0] den_i,
  output logic [NW-1:0]       num_mag_o,
  output logic [W:0]          den_mag_o,
  output logic                neg_o,
  output logic                den_zero_o,
  output logic [W-1:0]        zero_code_o
);
  function automatic logic signed [NW-1:0] upscale(input logic signed [W-1:0] v);
    logic signed [NW-1:0] e;
    e = {{(NW-W){v[W-1]}}, v};
    return e <<< QF;
  endfunction

  function automatic logic signed [W-1:0] half_toward_zero(input logic signed [W-1:0] v);
    logic signed [W-1:0] h;
    h = v >>> 1;
    if (v[W-1] && v[0]) h = h + W'(1);
    return h;
  endfunction

  function automatic logic [NW-1:0] mag_wide(input logic signed [NW-1:0] v);
    return v[NW-1] ? NW'(-v) : NW'(v);
  endfunction

  logic signed [NW-1:0] scaled, half_ext, corrected;
  logic signed [W:0]    den_ext;
  logic                 agree;

  always_comb begin
    scaled      = upscale(num_i);
    half_ext    = {{(NW-W){den_i[W-1]}}, half_toward_zero(den_i)};
    agree       = (scaled[NW-1] == den_i[W-1]);
    corrected   = agree ? (scaled + half_ext) : (scaled - half_ext);
    num_mag_o   = mag_wide(corrected);
    den_ext     = {den_i[W-1], den_i};
    den_mag_o   = den_ext[W] ? (W+1)'(-den_ext) : (W+1)'(den_ext);
    neg_o       = corrected[NW-1] ^ den_i[W-1];
    den_zero_o  = (den_i == '0);
    zero_code_o = num_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  end
endmodule

// File: rtl/qdiv_core.sv
// Restoring shift-subtract divider on magnitudes, one quotient bit per clock.
module qdiv_core
  import qdiv_pkg::*;
#(
  parameter int NW = 32,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [NW-1:0] quo_next_o
);
  localparam int CW = $clog2(NW);

  qd_state_e     st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rem, den_q, rem_n;
  logic [NW-1:0] dq;
  logic [DW:0]   shifted, diff;
  logic          fits;

  always_comb begin
    shifted    = {rem, dq[NW-1]};
    diff       = shifted - {1'b0, den_q};
    fits       = (shifted >= {1'b0, den_q});
    rem_n      = DW'(fits ? diff : shifted);
    quo_next_o = {dq[NW-2:0], fits};
    busy_o     = (st == ST_RUN);
    last_o     = busy_o && (cnt == CW'(NW - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      rem   <= '0;
      den_q <= '0;
      dq    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (load_i) begin
          rem   <= '0;
          dq    <= num_i;
          den_q <= den_i;
          cnt   <= '0;
          st    <= ST_RUN;
        end
        default: begin
          rem <= rem_n;
          dq  <= quo_next_o;
          cnt <= cnt + CW'(1);
          if (last_o) st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/qdiv_round.sv
// Top: start/busy/done handshake around the operand stage and serial core.
module qdiv_round #(
  parameter int W  = 16,
  parameter int QF = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] dividend,
  input  logic signed [W-1:0] divisor,
  output logic                busy,
  output logic                done,
  output logic [W-1:0]        quotient,
  output logic                div_by_zero
);
  localparam int NW = 2 * W;
  localparam int DW = W + 1;

  logic [NW-1:0] num_mag, quo_next;
  logic [DW-1:0] den_mag;
  logic          neg_w, den_zero, neg_q;
  logic [W-1:0]  zero_code, mag_lo, signed_res;
  logic          accept, zero_hit, load, last_step;

  qdiv_prep #(.W(W), .QF(QF), .NW(NW)) u_prep (
    .num_i(dividend), .den_i(divisor), .num_mag_o(num_mag), .den_mag_o(den_mag),
    .neg_o(neg_w), .den_zero_o(den_zero), .zero_code_o(zero_code)
  );

  qdiv_core #(.NW(NW), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(load), .num_i(num_mag), .den_i(den_mag),
    .busy_o(busy), .last_o(last_step), .quo_next_o(quo_next)
  );

  // Named events for the checker and for reading.
  assign accept   = start && !busy;
  assign zero_hit = accept && den_zero;
  assign load     = accept && !den_zero;

  always_comb begin
    mag_lo     = W'(quo_next);
    signed_res = neg_q ? (~mag_lo + W'(1)) : mag_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      quotient    <= '0;
      div_by_zero <= 1'b0;
      neg_q       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) neg_q <= neg_w;
      if (zero_hit) begin
        done        <= 1'b1;
        div_by_zero <= 1'b1;
        quotient    <= zero_code;
      end else if (last_step) begin
        done        <= 1'b1;
        div_by_zero <= 1'b0;
        quotient    <= signed_res;
      end
    end
  end
endmodule

// File: rtl/qdiv_round_chk.sv
module qdiv_round_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic         div_by_zero
);
  localparam int ITER = 2 * W;
  localparam int RC   = $clog2(ITER) + 1;

  logic [RC-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + RC'(1);
    else           run_cnt <= '0;
  end

  // R2: an accepted nonzero request raises busy next cycle
  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0) |=> busy);
  // R2: done never overlaps busy
  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2: busy only drops together with a done pulse
  a_r2_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R3: a start during a run does not lengthen or restart it
  a_r3_fixed_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RC'(ITER)));
  // R7: zero divisor finishes at once with the flag set
  a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_by_zero && !busy));
  // R7: the flag comes only with one of the two fixed codes
  a_r7_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> (quotient == {1'b0, {(W-1){1'b1}}} || quotient == {1'b1, {(W-1){1'b0}}}));
  // R8: outputs are held between completions
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(div_by_zero)));
endmodule

bind qdiv_round qdiv_round_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor), .busy(busy),
  .done(done), .quotient(quotient), .div_by_zero(div_by_zero)
);

// File: tb/sim_qdiv_round.sv
module sim_qdiv_round;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] a = '0, b = '0;
  logic busy0, done0, dbz0, busy1, done1, dbz1;
  logic [15:0] q0, q1;
  int n_chk = 0, n_bad = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qdiv_round #(.W(16), .QF(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(a), .divisor(b),
    .busy(busy0), .done(done0), .quotient(q0), .div_by_zero(dbz0));
  qdiv_round #(.W(16), .QF(0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(a), .divisor(b),
    .busy(busy1), .done(done1), .quotient(q1), .div_by_zero(dbz1));

  // Integer restatement of the rounding rule (R4).
  function automatic logic [15:0] ref_div(input int x, input int y, input int qf);
    longint t, h, r;
    if (y == 0) return (x < 0) ? 16'h8000 : 16'h7FFF;
    t = longint'(x) * (longint'(1) << qf);
    h = longint'(y / 2);
    if ((t >= 0 && y >= 0) || (t < 0 && y < 0)) t = t + h;
    else t = t - h;
    r = t / longint'(y);
    return r[15:0];
  endfunction

  // Behavioural timing model.
  bit m_busy, m_done, m_dbz;
  int m_cnt;
  logic [15:0] m_q0, m_q1, p_q0, p_q1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_dbz <= 0; m_cnt <= 0;
      m_q0 <= '0; m_q1 <= '0; p_q0 <= '0; p_q1 <= '0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_cnt == 31) begin
          m_busy <= 0; m_done <= 1; m_dbz <= 0; m_q0 <= p_q0; m_q1 <= p_q1;
        end
        m_cnt <= m_cnt + 1;
      end else if (start) begin
        if (b == 0) begin
          m_done <= 1; m_dbz <= 1;
          m_q0 <= ref_div(int'(a), 0, 8); m_q1 <= ref_div(int'(a), 0, 0);
        end else begin
          m_busy <= 1; m_cnt <= 0;
          p_q0 <= ref_div(int'(a), int'(b), 8); p_q1 <= ref_div(int'(a), int'(b), 0);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_on) begin
    chk(busy0 == m_busy && busy1 == m_busy, "R2 busy", {15'd0, busy0}, {15'd0, m_busy});
    chk(done0 == m_done && done1 == m_done, "R2 done", {15'd0, done0}, {15'd0, m_done});
    chk(q0 == m_q0, "R4 quotient QF=8", q0, m_q0);
    chk(q1 == m_q1, "R10 quotient QF=0", q1, m_q1);
    chk(dbz0 == m_dbz && dbz1 == m_dbz, "R7 div_by_zero", {15'd0, dbz0}, {15'd0, m_dbz});
  end

  task automatic wait_done();
    for (int i = 0; i < 40 && !m_done; i++) @(negedge clk);
  endtask

  task automatic op(input logic signed [15:0] x, input logic signed [15:0] y);
    @(negedge clk); a = x; b = y; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
  endtask

  function automatic logic signed [15:0] pick_div();
    case ($urandom_range(0, 7))
      0: return 16'sd0;
      1: return 16'sd1;
      2: return -16'sd2;
      3: return 16'sh8000;
      4: return 16'sh7FFF;
      5: return 16'($signed($urandom_range(0, 15)) - 8);
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values
    chk(!busy0 && !done0 && !dbz0 && q0 == 16'h0, "R1 reset state", q0, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy0 && !done0 && !dbz0 && q0 == 16'h0, "R1 after reset", {15'd0, busy0}, 16'h0);
    cmp_on = 1'b1;

    // R5: exact halves round away from zero
    op(16'sd1, 16'sd512);   chk(q0 == 16'h0001, "R5 +half", q0, 16'h0001);
    op(-16'sd1, 16'sd512);  chk(q0 == 16'hFFFF, "R5 -half", q0, 16'hFFFF);
    // R6: wrap without saturation
    op(16'sh7FFF, 16'sd1);  chk(q0 == 16'hFF00, "R6 wrap pos", q0, 16'hFF00);
    op(16'sh8000, 16'sd1);  chk(q0 == 16'h0000, "R6 wrap neg", q0, 16'h0000);
    // R9: most negative operands
    op(16'sh8000, 16'sh8000);
    chk(q0 == 16'h0100, "R9 QF=8", q0, 16'h0100);
    chk(q1 == 16'h0001, "R9 QF=0", q1, 16'h0001);
    // R10: no upscale
    op(16'sd7, 16'sd2);   chk(q1 == 16'h0004, "R10 7/2", q1, 16'h0004);
    op(-16'sd7, 16'sd2);  chk(q1 == 16'hFFFC, "R10 -7/2", q1, 16'hFFFC);
    // R7: zero divisor
    op(16'sd5, 16'sd0);
    chk(dbz0 && q0 == 16'h7FFF, "R7 non-negative", q0, 16'h7FFF);
    op(-16'sd3, 16'sd0);
    chk(dbz0 && q0 == 16'h8000, "R7 negative", q0, 16'h8000);
    // R8: held between completions, flag cleared by a good division
    repeat (5) @(negedge clk);
    chk(dbz0 && q0 == 16'h8000, "R8 hold", q0, 16'h8000);
    op(16'sd256, 16'sd256);
    chk(!dbz0 && q0 == 16'h0100, "R8 flag cleared", q0, 16'h0100);

    // R3: a second start during a run is ignored
    @(negedge clk); a = 16'sd1; b = 16'sd512; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    a = 16'sh7FFF; b = 16'sd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(q0 == 16'h0001, "R3 ignored start", q0, 16'h0001);

    // Random traffic, starts at arbitrary moments (R2, R3, R4).
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      start = ($urandom_range(0, 5) == 0);
      a = 16'($urandom);
      b = pick_div();
    end
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);

    summary();
    $finish;
  end
endmodule